// File: doc/BRIEF.md
# Two-Dimensional Strided DMA Engine

This block copies a rectangular region of word-addressed memory. Software sets up two independent walkers through a small register port. The fetch side reads words from a memory-read port and the store side writes them through a memory-write port. Each walker covers its region one line at a time. It is described by a first word address, a line length, a number of lines and a line pitch, all counted in bus words. An eight-entry FIFO sits between the two walkers. The two sides may therefore have different shapes as long as they move the same number of words.

Two further modes replace one walker with a valid/ready stream. In stream-in mode, words arriving on the input stream go into the FIFO and the store walker writes them to memory. In stream-out mode, the fetch walker fills the FIFO and the FIFO drains onto the output stream. Each walker has a busy flag and a sticky completion flag. A level interrupt combines the completion flags, each gated by its own enable.

Top module: `dma2d_top`

## Requirements
- R1: After reset the status register reads 0, `irq` is 0, `mrd_en` and `mwr_en` are 0, and with the reset mode both `s_ready` and `m_valid` are 0.
- R2: Register byte offsets are as follows.
  - 0x00 control: bit0 starts fetch, bit1 starts store, bit2 enables the fetch interrupt, bit3 enables the store interrupt, bits 5:4 hold the mode (0 memory-to-memory, 1 stream-in, 2 stream-out, 3 treated as 0).
  - 0x04 status: bit0 fetch busy, bit1 store busy, bit2 fetch done, bit3 store done.
  - 0x08 clear: writing 1 to bit0 clears fetch done, writing 1 to bit1 clears store done.
  - 0x10/0x14/0x18/0x1C: fetch start word, line length, line count and pitch.
  - 0x20/0x24/0x28/0x2C: the same four settings for store.
  - Setting registers and the enable and mode bits read back as written. Start bits read as 0.
- R3: A walker visits word k of line n at word address start + n*pitch + k. Lines go in ascending n and words in ascending k. The byte address on the memory port is the word address shifted left by log2 of the bus width in bytes.
- R4: In memory-to-memory mode the store walker writes the words in the order the fetch walker read them, with no loss and no duplication.
- R5: A start with line length 0 or line count 0 sets that side's done bit at the write edge. It leaves the side idle and makes no memory access.
- R6: A start written to a side that is busy is ignored. The running transfer finishes with the settings it was started with.
- R7: Read data returns one cycle after `mrd_en`. The fetch walker never has more words stored plus in flight than the FIFO depth (8), and the store walker waits while the FIFO is empty.
- R8: The busy bits are independent. A side is busy from the start write until its last word is issued.
- R9: A done bit is set when its side finishes and stays set until cleared. `irq` is high exactly when some done bit is set and its enable is set.
- R10: In stream-in mode the FIFO is filled from `s_data` when `s_valid` and `s_ready` are both high. `s_ready` is high when the FIFO is not full. A fetch start is ignored.
- R11: In stream-out mode `m_valid` is high when the FIFO holds data and `m_data` is its oldest word. A word leaves when `m_ready` is high. A store start is ignored.
- R12: In memory-to-memory mode `s_ready` and `m_valid` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | CSR_AW | Register byte offset |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Register read data for `csr_addr` |
| irq | output | 1 | Completion interrupt |
| mrd_en | output | 1 | Memory read request |
| mrd_addr | output | ADDR_W | Memory read byte address |
| mrd_data | input | DATA_W | Read data, one cycle after `mrd_en` |
| mwr_en | output | 1 | Memory write strobe |
| mwr_addr | output | ADDR_W | Memory write byte address |
| mwr_data | output | DATA_W | Memory write data |
| s_valid | input | 1 | Input stream valid |
| s_data | input | DATA_W | Input stream data |
| s_ready | output | 1 | Input stream ready |
| m_valid | output | 1 | Output stream valid |
| m_data | output | DATA_W | Output stream data |
| m_ready | input | 1 | Output stream ready |

## Verification
The assertions assume that the memory returns data on the cycle after every request without fail. They also assume that the mode field is not rewritten while a side is busy. The bench's memory model always answers with one cycle of latency. It changes the mode only after polling status until both busy bits are clear. Random regions keep source and destination word ranges apart, so a copy can be checked after it completes against the untouched source words.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  localparam int CSR_DW = 32;

  typedef enum logic [1:0] {
    MODE_M2M = 2'd0,
    MODE_S2M = 2'd1,
    MODE_M2S = 2'd2
  } xfer_mode_e;

  localparam logic [7:0] OFS_CTRL   = 8'h00;
  localparam logic [7:0] OFS_STATUS = 8'h04;
  localparam logic [7:0] OFS_CLEAR  = 8'h08;
  localparam logic [7:0] OFS_SIDE0  = 8'h10;
  localparam logic [7:0] OFS_SIDE1  = 8'h20;
endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int CNT_W   = 16,
  parameter int CSR_AW  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     csr_we,
  input  logic [CSR_AW-1:0]        csr_addr,
  input  logic [CSR_DW-1:0]        csr_wdata,
  output logic [CSR_DW-1:0]        csr_rdata,
  input  logic [1:0]               busy,
  input  logic [1:0]               fin,
  output logic [1:0]               start,
  output logic [1:0][WADDR_W-1:0]  set_base,
  output logic [1:0][CNT_W-1:0]    set_len,
  output logic [1:0][CNT_W-1:0]    set_cnt,
  output logic [1:0][CNT_W-1:0]    set_pitch,
  output xfer_mode_e               mode,
  output logic                     irq
);
  logic [1:0] ie_q, ie_d, done_q, done_d;
  xfer_mode_e mode_q, mode_d, new_mode;
  logic ctrl_wr, clr_wr;

  always_comb begin
    ctrl_wr = csr_we && (csr_addr == CSR_AW'(OFS_CTRL));
    clr_wr  = csr_we && (csr_addr == CSR_AW'(OFS_CLEAR));
    case (csr_wdata[5:4])
      2'd1:    new_mode = MODE_S2M;
      2'd2:    new_mode = MODE_M2S;
      default: new_mode = MODE_M2M;
    endcase
    start[0] = ctrl_wr && csr_wdata[0] && (new_mode != MODE_S2M);
    start[1] = ctrl_wr && csr_wdata[1] && (new_mode != MODE_M2S);
    ie_d     = ctrl_wr ? csr_wdata[3:2] : ie_q;
    mode_d   = ctrl_wr ? new_mode : mode_q;
    for (int s = 0; s < 2; s++)
      done_d[s] = fin[s] | (done_q[s] & ~(clr_wr & csr_wdata[s]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= '0;
      mode_q <= MODE_M2M;
      done_q <= '0;
    end else begin
      ie_q   <= ie_d;
      mode_q <= mode_d;
      done_q <= done_d;
    end
  end

  // setting registers, one block of four per side
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_base  <= '0;
      set_len   <= '0;
      set_cnt   <= '0;
      set_pitch <= '0;
    end else if (csr_we) begin
      for (int s = 0; s < 2; s++) begin
        if (csr_addr == CSR_AW'(16 + 16*s))
          set_base[s]  <= csr_wdata[WADDR_W-1:0];
        if (csr_addr == CSR_AW'(20 + 16*s))
          set_len[s]   <= csr_wdata[CNT_W-1:0];
        if (csr_addr == CSR_AW'(24 + 16*s))
          set_cnt[s]   <= csr_wdata[CNT_W-1:0];
        if (csr_addr == CSR_AW'(28 + 16*s))
          set_pitch[s] <= csr_wdata[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    csr_rdata = '0;
    if (csr_addr == CSR_AW'(OFS_CTRL))
      csr_rdata[5:0] = {mode_q, ie_q, 2'b00};
    if (csr_addr == CSR_AW'(OFS_STATUS))
      csr_rdata[3:0] = {done_q, busy};
    for (int s = 0; s < 2; s++) begin
      if (csr_addr == CSR_AW'(16 + 16*s)) csr_rdata = CSR_DW'(set_base[s]);
      if (csr_addr == CSR_AW'(20 + 16*s)) csr_rdata = CSR_DW'(set_len[s]);
      if (csr_addr == CSR_AW'(24 + 16*s)) csr_rdata = CSR_DW'(set_cnt[s]);
      if (csr_addr == CSR_AW'(28 + 16*s)) csr_rdata = CSR_DW'(set_pitch[s]);
    end
  end

  assign mode = mode_q;
  assign irq  = |(done_q & ie_q);
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker #(
  parameter int WADDR_W = 30,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WADDR_W-1:0] base,
  input  logic [CNT_W-1:0]   len,
  input  logic [CNT_W-1:0]   cnt,
  input  logic [CNT_W-1:0]   pitch,
  input  logic               step,
  output logic               busy,
  output logic [WADDR_W-1:0] addr,
  output logic               fin
);
  logic               busy_q, busy_d;
  logic [WADDR_W-1:0] line_q, line_d;
  logic [CNT_W-1:0]   k_q, k_d, n_q, n_d;
  logic [CNT_W-1:0]   len_q, cnt_q, pitch_q;
  logic               load, advance, last_k, last_n, empty_job;

  always_comb begin
    empty_job = (len == '0) || (cnt == '0);
    load      = start && !busy_q && !empty_job;
    advance   = busy_q && step;
    last_k    = (k_q == len_q - CNT_W'(1));
    last_n    = (n_q == cnt_q - CNT_W'(1));
    fin       = (start && !busy_q && empty_job) || (advance && last_k && last_n);
    busy_d = busy_q;
    line_d = line_q;
    k_d    = k_q;
    n_d    = n_q;
    if (load) begin
      busy_d = 1'b1;
      line_d = base;
      k_d    = '0;
      n_d    = '0;
    end else if (advance) begin
      if (last_k) begin
        k_d    = '0;
        n_d    = n_q + CNT_W'(1);
        line_d = line_q + WADDR_W'(pitch_q);
        if (last_n) busy_d = 1'b0;
      end else begin
        k_d = k_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      line_q  <= '0;
      k_q     <= '0;
      n_q     <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      pitch_q <= '0;
    end else begin
      busy_q <= busy_d;
      line_q <= line_d;
      k_q    <= k_d;
      n_q    <= n_d;
      if (load) begin
        len_q   <= len;
        cnt_q   <= cnt;
        pitch_q <= pitch;
      end
    end
  end

  assign busy = busy_q;
  assign addr = line_q + WADDR_W'(k_q);
endmodule

// File: rtl/dma2d_fifo.sv
module dma2d_fifo #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  localparam int PW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] wdata,
  input  logic              pop,
  output logic [DATA_W-1:0] rdata,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]     cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (push) wp_d = (wp_q == PW'(DEPTH - 1)) ? '0 : wp_q + PW'(1);
    if (pop)  rp_d = (rp_q == PW'(DEPTH - 1)) ? '0 : rp_q + PW'(1);
    if (push && !pop) cnt_d = cnt_q + CW'(1);
    if (pop && !push) cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) store[wp_q] <= wdata;
  end

  assign rdata = store[rp_q];
  assign count = cnt_q;
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);
endmodule

// File: rtl/dma2d_top.sv
module dma2d_top
  import dma2d_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int CSR_AW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  output logic              irq,
  output logic              mrd_en,
  output logic [ADDR_W-1:0] mrd_addr,
  input  logic [DATA_W-1:0] mrd_data,
  output logic              mwr_en,
  output logic [ADDR_W-1:0] mwr_addr,
  output logic [DATA_W-1:0] mwr_data,
  input  logic              s_valid,
  input  logic [DATA_W-1:0] s_data,
  output logic              s_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  input  logic              m_ready
);
  localparam int SH      = $clog2(DATA_W / 8);
  localparam int WADDR_W = ADDR_W - SH;
  localparam int CW      = $clog2(FIFO_DEPTH + 1);

  logic       rst_meta, rst_sync;
  logic [1:0] start, busy, fin, step;
  logic [1:0][WADDR_W-1:0] set_base, waddr;
  logic [1:0][CNT_W-1:0]   set_len, set_cnt, set_pitch;
  xfer_mode_e mode;
  logic              rd_pend;
  logic              fifo_push, fifo_pop, fifo_full, fifo_empty;
  logic [DATA_W-1:0] fifo_wdata, fifo_rdata;
  logic [CW-1:0]     fifo_count;

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  dma2d_regs #(.WADDR_W(WADDR_W), .CNT_W(CNT_W), .CSR_AW(CSR_AW)) u_regs (
    .clk(clk), .rst_n(rst_sync), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .busy(busy), .fin(fin),
    .start(start), .set_base(set_base), .set_len(set_len),
    .set_cnt(set_cnt), .set_pitch(set_pitch), .mode(mode), .irq(irq)
  );

  generate
    for (genvar s = 0; s < 2; s++) begin : g_walk
      dma2d_walker #(.WADDR_W(WADDR_W), .CNT_W(CNT_W)) u_walk (
        .clk(clk), .rst_n(rst_sync), .start(start[s]), .base(set_base[s]),
        .len(set_len[s]), .cnt(set_cnt[s]), .pitch(set_pitch[s]),
        .step(step[s]), .busy(busy[s]), .addr(waddr[s]), .fin(fin[s])
      );
    end
  endgenerate

  // fetch issues only with a free FIFO slot counting the read in flight
  always_comb begin
    step[0] = busy[0] && (mode != MODE_S2M) &&
              ((CW + 1)'(fifo_count) + (CW + 1)'(rd_pend) < (CW + 1)'(FIFO_DEPTH));
    step[1] = busy[1] && (mode != MODE_M2S) && !fifo_empty;
    s_ready = (mode == MODE_S2M) && !fifo_full;
    m_valid = (mode == MODE_M2S) && !fifo_empty;
    fifo_push  = (mode == MODE_S2M) ? (s_valid && s_ready) : rd_pend;
    fifo_wdata = (mode == MODE_S2M) ? s_data : mrd_data;
    fifo_pop   = (mode == MODE_M2S) ? (m_valid && m_ready) : step[1];
  end

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) rd_pend <= 1'b0;
    else           rd_pend <= step[0];
  end

  dma2d_fifo #(.DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_sync), .push(fifo_push), .wdata(fifo_wdata),
    .pop(fifo_pop), .rdata(fifo_rdata), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty)
  );

  assign mrd_en   = step[0];
  assign mrd_addr = {waddr[0], {SH{1'b0}}};
  assign mwr_en   = step[1];
  assign mwr_addr = {waddr[1], {SH{1'b0}}};
  assign mwr_data = fifo_rdata;
  assign m_data   = fifo_rdata;
endmodule

// File: rtl/dma2d_chk.sv
module dma2d_chk #(
  parameter int CSR_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fifo_push,
  input logic              fifo_pop,
  input logic              fifo_full,
  input logic              fifo_empty,
  input logic              mrd_en,
  input logic [1:0]        mode,
  input logic              s_ready,
  input logic              m_valid,
  input logic              csr_we,
  input logic [CSR_AW-1:0] csr_addr,
  input logic [31:0]       csr_wdata,
  input logic [1:0]        fin,
  input logic              irq
);
  // R7
  fifo_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_push |-> !fifo_full);
  // R7
  fifo_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> !fifo_empty);
  // R7
  read_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mrd_en && mode != 2'd1) |=> (fifo_push || mode == 2'd1));
  // R12
  m2m_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (!s_ready && !m_valid));
  // R9
  irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_we && csr_addr == CSR_AW'(8) && csr_wdata[1:0] == 2'b11 && fin == 2'b00)
    |=> !irq);
endmodule

bind dma2d_top dma2d_chk #(.CSR_AW(CSR_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_push(fifo_push), .fifo_pop(fifo_pop),
  .fifo_full(fifo_full), .fifo_empty(fifo_empty), .mrd_en(mrd_en),
  .mode(mode), .s_ready(s_ready), .m_valid(m_valid), .csr_we(csr_we),
  .csr_addr(csr_addr), .csr_wdata(csr_wdata), .fin(fin), .irq(irq)
);

// File: tb/sim_dma2d_top.sv
module sim_dma2d_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        csr_we;
  logic [5:0]  csr_addr;
  logic [31:0] csr_wdata, csr_rdata;
  logic        irq, mrd_en, mwr_en, s_valid, s_ready, m_valid, m_ready;
  logic [31:0] mrd_addr, mwr_addr, mwr_data, s_data, m_data;
  logic [31:0] mrd_data;

  int checks = 0, failures = 0;
  int rd_beats = 0, wr_beats = 0, m_got = 0;
  logic [31:0] mem [256];
  logic [31:0] m_seq [64];

  always #5 clk = ~clk;

  dma2d_top u0 (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq),
    .mrd_en(mrd_en), .mrd_addr(mrd_addr), .mrd_data(mrd_data),
    .mwr_en(mwr_en), .mwr_addr(mwr_addr), .mwr_data(mwr_data),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .m_valid(m_valid), .m_data(m_data), .m_ready(m_ready)
  );

  // memory model: one cycle read latency
  always @(posedge clk) begin
    if (mrd_en) begin
      mrd_data <= mem[mrd_addr[9:2]];
      rd_beats <= rd_beats + 1;
    end
    if (mwr_en) begin
      mem[mwr_addr[9:2]] <= mwr_data;
      wr_beats <= wr_beats + 1;
    end
    if (m_valid && m_ready) begin
      m_seq[m_got[5:0]] <= m_data;
      m_got <= m_got + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic csr_write(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [5:0] a, output logic [31:0] d);
    csr_addr = a;
    #1 d = csr_rdata;
  endtask

  task automatic set_side(input int side, input int base, input int len, input int cnt, input int pitch);
    logic [5:0] o;
    o = (side == 0) ? 6'h10 : 6'h20;
    csr_write(o, base);
    csr_write(o + 6'd4, len);
    csr_write(o + 6'd8, cnt);
    csr_write(o + 6'd12, pitch);
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    do begin
      @(negedge clk);
      csr_read(6'h04, st);
    end while (st[1:0] != 2'b00);
    repeat (2) @(negedge clk);
  endtask

  function automatic int walk(input int base, input int len, input int pitch, input int i);
    return base + (i / len) * pitch + (i % len);
  endfunction

  task automatic fill_src();
    for (int i = 0; i < 256; i++) mem[i] = (i < 128) ? $urandom : 32'hDEAD0000 + i;
  endtask

  // R3 R4: compare destination walk against source walk
  task automatic check_copy(input string req, input int rb, input int rl, input int rp,
                            input int wb, input int wl, input int wp, input int total);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < total; i++) begin
      if (mem[walk(wb, wl, wp, i)] !== mem[walk(rb, rl, rp, i)]) begin
        bad++;
        if (first < 0) first = i;
      end
    end
    chk(bad == 0, req, (first < 0) ? 0 : mem[walk(wb, wl, wp, first)],
        (first < 0) ? 0 : mem[walk(rb, rl, rp, first)]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int rb0, wb0;
    void'($urandom(32'h5EED1234));
    csr_we = 0; csr_addr = 0; csr_wdata = 0;
    s_valid = 0; s_data = 0; m_ready = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state, R12 default mode idles streams
    csr_read(6'h04, r);
    chk(r == 0, "R1 status", r, 0);
    chk(irq == 0 && mrd_en == 0 && mwr_en == 0, "R1 outputs", {irq, mrd_en, mwr_en}, 0);
    chk(s_ready == 0 && m_valid == 0, "R12 streams idle", {s_ready, m_valid}, 0);

    // R2 readback
    set_side(0, 4, 3, 4, 5);
    csr_read(6'h1C, r); chk(r == 5, "R2 pitch readback", r, 5);
    csr_read(6'h14, r); chk(r == 3, "R2 len readback", r, 3);
    csr_write(6'h00, 32'h0C);
    csr_read(6'h00, r); chk(r == 32'h0C, "R2 ctrl readback", r, 32'h0C);

    // R3 R4 R9 directed copy
    fill_src();
    set_side(1, 130, 6, 2, 8);
    rb0 = rd_beats; wb0 = wr_beats;
    csr_write(6'h00, 32'h0F);
    csr_read(6'h04, r);
    chk(r[1:0] == 2'b11, "R8 both busy", r, 3);
    wait_idle();
    check_copy("R3 R4 directed copy", 4, 3, 5, 130, 6, 8, 12);
    chk(rd_beats - rb0 == 12 && wr_beats - wb0 == 12, "R4 beat count", rd_beats - rb0, 12);
    csr_read(6'h04, r); chk(r == 32'h0C, "R9 done bits", r, 32'h0C);
    chk(irq == 1, "R9 irq set", irq, 1);
    csr_write(6'h08, 32'h1);
    chk(irq == 1, "R9 irq held by store", irq, 1);
    csr_write(6'h08, 32'h2);
    chk(irq == 0, "R9 irq cleared", irq, 0);

    // R5 zero length and zero count, irq gated off
    csr_write(6'h00, 32'h00);
    set_side(0, 0, 0, 3, 1);
    set_side(1, 150, 2, 0, 2);
    rb0 = rd_beats; wb0 = wr_beats;
    csr_write(6'h00, 32'h03);
    csr_read(6'h04, r);
    chk(r == 32'h0C, "R5 zero done", r, 32'h0C);
    chk(irq == 0, "R9 irq gated", irq, 0);
    repeat (3) @(negedge clk);
    chk(rd_beats == rb0 && wr_beats == wb0, "R5 no access", rd_beats - rb0, 0);
    csr_write(6'h08, 32'h3);

    // R7 backpressure: fetch alone stops at FIFO depth
    fill_src();
    set_side(0, 40, 5, 4, 6);
    set_side(1, 200, 10, 2, 10);
    rb0 = rd_beats;
    csr_write(6'h00, 32'h01);
    repeat (40) @(negedge clk);
    chk(rd_beats - rb0 == 8, "R7 fetch stalls at depth", rd_beats - rb0, 8);
    csr_read(6'h04, r); chk(r[1:0] == 2'b01, "R8 fetch busy only", r[1:0], 1);
    csr_write(6'h00, 32'h02);
    wait_idle();
    check_copy("R7 copy after stall", 40, 5, 6, 200, 10, 10, 20);
    csr_write(6'h08, 32'h3);

    // R6 restart while busy ignored
    fill_src();
    set_side(0, 0, 10, 3, 12);
    set_side(1, 140, 15, 2, 20);
    rb0 = rd_beats;
    csr_write(6'h00, 32'h03);
    csr_write(6'h14, 32'd1);
    csr_write(6'h00, 32'h03);
    wait_idle();
    chk(rd_beats - rb0 == 30, "R6 restart ignored", rd_beats - rb0, 30);
    check_copy("R6 copy intact", 0, 10, 12, 140, 15, 20, 30);
    csr_write(6'h08, 32'h3);

    // R10 stream-in, fetch start ignored
    for (int i = 0; i < 256; i++) mem[i] = 0;
    set_side(1, 140, 4, 3, 6);
    rb0 = rd_beats;
    csr_write(6'h00, 32'h13);
    csr_read(6'h04, r); chk(r[1:0] == 2'b10, "R10 fetch start ignored", r[1:0], 2);
    for (int i = 0; i < 12; i++) begin
      s_valid = 1'b1; s_data = 32'hA000 + i;
      #1;
      while (!s_ready) begin @(negedge clk); #1; end
      @(negedge clk);
    end
    s_valid = 1'b0;
    wait_idle();
    begin
      int bad = 0;
      for (int i = 0; i < 12; i++) if (mem[walk(140, 4, 6, i)] != 32'hA000 + i) bad++;
      chk(bad == 0 && rd_beats == rb0, "R10 stream-in stored", bad, 0);
    end
    csr_write(6'h08, 32'h3);

    // R11 stream-out with random ready, store start ignored
    fill_src();
    set_side(0, 10, 3, 3, 4);
    m_got = 0;
    csr_write(6'h00, 32'h23);
    csr_read(6'h04, r); chk(r[1:0] == 2'b01, "R11 store start ignored", r[1:0], 1);
    for (int c = 0; c < 200 && m_got < 9; c++) begin
      m_ready = $urandom_range(0, 1);
      @(negedge clk);
    end
    m_ready = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 9; i++) if (m_seq[i] != mem[walk(10, 3, 4, i)]) bad++;
      chk(bad == 0 && m_got == 9, "R11 stream-out order", m_got, 9);
    end
    repeat (3) @(negedge clk);
    chk(m_valid == 0, "R11 drained", m_valid, 0);
    csr_write(6'h08, 32'h3);

    // R3 R4 random regions
    csr_write(6'h00, 32'h00);
    for (int t = 0; t < 8; t++) begin
      int rl, rc, rp, rb, wp, wb;
      rl = $urandom_range(1, 4); rc = $urandom_range(1, 4);
      rp = rl + $urandom_range(0, 3); rb = $urandom_range(0, 100);
      wp = rc + $urandom_range(0, 3); wb = $urandom_range(128, 180);
      fill_src();
      set_side(0, rb, rl, rc, rp);
      set_side(1, wb, rc, rl, wp);
      csr_write(6'h00, 32'h03);
      wait_idle();
      check_copy("R3 R4 random copy", rb, rl, rp, wb, rc, wp, rl * rc);
      csr_write(6'h08, 32'h3);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule